// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Address Marking

This block turns bytes written by a host into an asynchronous serial bit stream on `txd`. A character is a low start bit, then 5 to 8 data bits least significant first, then an optional extra bit, then one or two high stop bits. The extra bit carries either parity (even or odd) or, in multidrop mode, an address/data marker chosen by the host. The block times its bits from a 16X clock enable produced elsewhere. A single holding register sits in front of the shift path, so the host can queue the next byte while the current one is on the line.

The host drives single-cycle command pulses. These turn the transmitter on and off, start and stop a break, and raise and drop RTS. Turning the transmitter off refuses new bytes, but the character in flight and any byte already held are still sent. An active-low clear-to-send input can hold back the start of each character. RTS can also be dropped automatically once the line falls silent. `tx_rdy` tells the host that the holding register can take a byte, and `tx_emt` shows that both the shifter and the holding register are empty.

The controller has seven states. ST_IDLE holds the line high. It moves to ST_START when a byte is held and clear-to-send allows it, and that move restarts the bit clock. ST_START moves to ST_DATA after one bit time. ST_DATA moves to ST_PAR after the last data bit when an extra bit is configured, and to ST_STOP1 otherwise. ST_PAR moves to ST_STOP1. ST_STOP1 moves to ST_STOP2 when two stop bits are configured. At the end of the last stop bit the controller chains into ST_START if a byte is waiting and clear-to-send allows it, and returns to ST_IDLE otherwise. A break-start pulse forces ST_BREAK from any state, abandoning a character in flight. ST_BREAK drives the line low and returns to ST_IDLE on a break-stop pulse.

Top module: `serial_tx`

## Requirements
- R1: A frame is a 0 start bit, then `cfg_len`+5 data bits sent least significant bit first (`cfg_len` 0..3 gives 5..8 bits), then the stop bits, each at 1. Every bit lasts 16 `tick16` pulses.
- R2: When no character is being sent and the holding register is empty, `txd` is 1 and `tx_emt` is 1. An accepted write clears `tx_emt` and a frame follows.
- R3: A byte written while the line is idle starts its start bit no more than 2 clock cycles after the write cycle. The bit clock is restarted at that point.
- R4: With `cfg_par_en`=1 and `cfg_multidrop`=0, a bit follows the data bits. For `cfg_par_odd`=0 it equals the XOR of the sent data bits; for `cfg_par_odd`=1 it is the inverse of that XOR.
- R5: With `cfg_multidrop`=1, the bit after the data bits equals `cfg_addr_flag` (1 marks an address, 0 marks data), whatever the parity settings are.
- R6: With `cfg_two_stop`=1, two stop-bit times at 1 separate a frame from the next start bit, even when a byte is already waiting.
- R7: From the cycle after a `cmd_brk_start` pulse, `txd` is 0 until `cmd_brk_stop`. A character in progress is abandoned. After the stop pulse the line returns to 1.
- R8: `tx_rdy` is 1 exactly when the transmitter is enabled and the holding register is empty. Writes while disabled are ignored: no frame follows and `tx_emt` stays 1.
- R9: After `cmd_tx_off`, the character being shifted and the byte already held are both sent in full.
- R10: With `cfg_cts_en`=1 and `cts_n`=1, no new character starts. The character starts once `cts_n` goes to 0.
- R11: `cmd_rts_on` drives `rts_n` to 0 and `cmd_rts_off` drives it to 1, each one cycle after the pulse.
- R12: With `cfg_auto_rts`=1, `rts_n` goes to 1 one cycle after `tx_emt` rises, unless `cmd_rts_on` is pulsed in that same cycle.
- R13: After reset, `txd`=1, `tx_rdy`=0 (transmitter disabled), `tx_emt`=1 and `rts_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16X bit-rate enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cmd_tx_on | input | 1 | Pulse: enable the transmitter |
| cmd_tx_off | input | 1 | Pulse: disable the transmitter (drains) |
| cmd_brk_start | input | 1 | Pulse: begin break |
| cmd_brk_stop | input | 1 | Pulse: end break |
| cmd_rts_on | input | 1 | Pulse: assert RTS (rts_n low) |
| cmd_rts_off | input | 1 | Pulse: negate RTS (rts_n high) |
| cfg_len | input | 2 | Data length code, bits = code + 5 |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_multidrop | input | 1 | Send the address/data marker instead of parity |
| cfg_addr_flag | input | 1 | Marker value for the next character |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_cts_en | input | 1 | Gate character starts with cts_n |
| cfg_auto_rts | input | 1 | Negate RTS automatically when the line empties |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| tx_rdy | output | 1 | Holding register can accept a byte |
| tx_emt | output | 1 | Shifter and holding register both empty |
| rts_n | output | 1 | Request to send, active low |

## Verification
On every cycle the assertions check several simple relations. An empty transmitter always marks the line. A break command is followed by a low line. A blocked clear-to-send keeps the controller out of ST_START. A write while disabled never fills the holding register. A byte loaded while idle starts its start bit on the next edge. Automatic RTS negation follows the empty flag. Other behaviour only shows across whole frames, so the bench's scenarios decode the line at bit centres. These cover bit order, data length, the parity or marker bit, the two-stop spacing between back-to-back characters, the drain of two bytes after disable, and the recovery to a clean frame after a break.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_BREAK
    } tx_state_e;

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic resync,
    output logic bit_tick
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (resync) begin
            phase_q <= '0;
        end else if (tick16) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign bit_tick = tick16 && !resync && (phase_q == LAST);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    logic          full_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b0;
            end
            if (en && wr_en) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end
        end
    end

    assign full = full_q;
    assign data = data_q;

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && wr_en && !full_q) |=> !full_q); // R8

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import serial_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_multidrop,
    input  logic          cfg_addr_flag,
    input  logic          cfg_two_stop,
    input  logic          cfg_cts_en,
    input  logic          cts_n,
    input  logic          brk_start,
    input  logic          brk_stop,
    output logic          take,
    output logic          resync,
    output logic          txd,
    output logic          idle
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     state_q, state_n;
    logic [DW-1:0] shift_q;
    logic [IW-1:0] bidx_q;
    logic [IW-1:0] last_q;
    logic          pbit_q;
    logic          xbit_q;
    logic          two_q;
    logic          load;
    logic          cts_ok;
    logic [DW-1:0] mask;
    logic          pbit_n;

    assign cts_ok = !cfg_cts_en || !cts_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full && cts_ok) begin
                    state_n = ST_START;
                    load    = 1'b1;
                end
            end
            ST_START: begin
                if (bit_tick) state_n = ST_DATA;
            end
            ST_DATA: begin
                if (bit_tick && bidx_q == last_q) begin
                    state_n = xbit_q ? ST_PAR : ST_STOP1;
                end
            end
            ST_PAR: begin
                if (bit_tick) state_n = ST_STOP1;
            end
            ST_STOP1: begin
                if (bit_tick) begin
                    if (two_q) begin
                        state_n = ST_STOP2;
                    end else if (hold_full && cts_ok) begin
                        state_n = ST_START;
                        load    = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_STOP2: begin
                if (bit_tick) begin
                    if (hold_full && cts_ok) begin
                        state_n = ST_START;
                        load    = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_BREAK: begin
                if (brk_stop) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
        if (brk_start) begin
            state_n = ST_BREAK;
            load    = 1'b0;
        end
    end

    // extra-bit value for the byte being launched
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i <= 4 + int'(cfg_len));
        end
        pbit_n = cfg_multidrop ? cfg_addr_flag
                               : ((^(hold_data & mask)) ^ cfg_par_odd);
    end

    // shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            bidx_q  <= '0;
            last_q  <= '0;
            pbit_q  <= 1'b0;
            xbit_q  <= 1'b0;
            two_q   <= 1'b0;
        end else if (load) begin
            shift_q <= hold_data;
            bidx_q  <= '0;
            last_q  <= IW'(4 + int'(cfg_len));
            pbit_q  <= pbit_n;
            xbit_q  <= cfg_par_en || cfg_multidrop;
            two_q   <= cfg_two_stop;
        end else if (state_q == ST_DATA && bit_tick) begin
            shift_q <= shift_q >> 1;
            bidx_q  <= bidx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shift_q[0];
            ST_PAR:   txd = pbit_q;
            ST_STOP1: txd = 1'b1;
            ST_STOP2: txd = 1'b1;
            ST_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    assign take   = load;
    assign resync = load && (state_q == ST_IDLE);
    assign idle   = (state_q == ST_IDLE);

    AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_en && cts_n && state_q == ST_IDLE) |=> (state_q != ST_START)); // R10

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !txd); // R7

    AST_QUICK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hold_full && cts_ok && !brk_start) |=> !txd); // R3

endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_tx_on,
    input  logic          cmd_tx_off,
    input  logic          cmd_brk_start,
    input  logic          cmd_brk_stop,
    input  logic          cmd_rts_on,
    input  logic          cmd_rts_off,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_multidrop,
    input  logic          cfg_addr_flag,
    input  logic          cfg_two_stop,
    input  logic          cfg_cts_en,
    input  logic          cfg_auto_rts,
    input  logic          cts_n,
    output logic          txd,
    output logic          tx_rdy,
    output logic          tx_emt,
    output logic          rts_n
);
    logic          en_q;
    logic          rts_q;
    logic          emt_d;
    logic          bit_tick;
    logic          resync;
    logic          take;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          fsm_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cmd_tx_off) begin
            en_q <= 1'b0;
        end else if (cmd_tx_on) begin
            en_q <= 1'b1;
        end
    end

    sertx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .resync   (resync),
        .bit_tick (bit_tick)
    );

    sertx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_fsm #(.DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .hold_full     (hold_full),
        .hold_data     (hold_data),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .cfg_multidrop (cfg_multidrop),
        .cfg_addr_flag (cfg_addr_flag),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_cts_en    (cfg_cts_en),
        .cts_n         (cts_n),
        .brk_start     (cmd_brk_start),
        .brk_stop      (cmd_brk_stop),
        .take          (take),
        .resync        (resync),
        .txd           (txd),
        .idle          (fsm_idle)
    );

    assign tx_emt = fsm_idle && !hold_full;
    assign tx_rdy = en_q && !hold_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_q <= 1'b0;
            emt_d <= 1'b1;
        end else begin
            emt_d <= tx_emt;
            if (cmd_rts_off) begin
                rts_q <= 1'b0;
            end else if (cmd_rts_on) begin
                rts_q <= 1'b1;
            end else if (cfg_auto_rts && tx_emt && !emt_d) begin
                rts_q <= 1'b0;
            end
        end
    end

    assign rts_n = !rts_q;

    AST_EMPTY_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> txd); // R2

    AST_AUTO_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && tx_emt && !emt_d && !cmd_rts_on) |=> rts_n); // R12

    AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tx_off |=> !tx_rdy); // R8

endmodule

// File: tb/serial_tx_bench.sv
module serial_tx_bench;
    localparam int BIT  = 32;   // tick16 every second cycle, 16 ticks per bit
    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_tx_on = 1'b0, cmd_tx_off = 1'b0;
    logic       cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0;
    logic       cmd_rts_on = 1'b0, cmd_rts_off = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_multidrop = 1'b0, cfg_addr_flag = 1'b0;
    logic       cfg_two_stop = 1'b0, cfg_cts_en = 1'b0, cfg_auto_rts = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd, tx_rdy, tx_emt, rts_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_tx u_serial_tx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .wr_en(wr_en), .wr_data(wr_data),
        .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off),
        .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
        .cmd_rts_on(cmd_rts_on), .cmd_rts_off(cmd_rts_off),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_multidrop(cfg_multidrop), .cfg_addr_flag(cfg_addr_flag),
        .cfg_two_stop(cfg_two_stop), .cfg_cts_en(cfg_cts_en),
        .cfg_auto_rts(cfg_auto_rts), .cts_n(cts_n),
        .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .rts_n(rts_n)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // which: 0 on, 1 off, 2 brk start, 3 brk stop, 4 rts on, 5 rts off
    task automatic cmd(input int which);
        @(negedge clk);
        case (which)
            0: cmd_tx_on = 1'b1;
            1: cmd_tx_off = 1'b1;
            2: cmd_brk_start = 1'b1;
            3: cmd_brk_stop = 1'b1;
            4: cmd_rts_on = 1'b1;
            default: cmd_rts_off = 1'b1;
        endcase
        @(negedge clk);
        cmd_tx_on = 1'b0; cmd_tx_off = 1'b0;
        cmd_brk_start = 1'b0; cmd_brk_stop = 1'b0;
        cmd_rts_on = 1'b0; cmd_rts_off = 1'b0;
    endtask

    task automatic rx_frame(input string req, input int nbits, input bit haspar,
                            input int nstop, output int data, output int par,
                            output int wait_cyc);
        int w = 0;
        while (txd !== 1'b0 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        wait_cyc = w;
        chk(req, "start bit seen", int'(w < 4000), 1);
        cyc(HALF);
        chk(req, "start bit centre", int'(txd), 0);
        data = 0;
        for (int i = 0; i < nbits; i++) begin
            cyc(BIT);
            data = data | (int'(txd) << i);
        end
        par = -1;
        if (haspar) begin
            cyc(BIT);
            par = int'(txd);
        end
        for (int s = 0; s < nstop; s++) begin
            cyc(BIT);
            chk(req, "stop bit", int'(txd), 1);
        end
    endtask

    task automatic t_reset();
        chk("R13", "txd after reset", int'(txd), 1);
        chk("R13", "tx_rdy after reset", int'(tx_rdy), 0);
        chk("R13", "tx_emt after reset", int'(tx_emt), 1);
        chk("R13", "rts_n after reset", int'(rts_n), 1);
    endtask

    task automatic t_basic();
        int d, p, w;
        cfg_len = 2'd3;
        cmd(0);
        chk("R8", "tx_rdy when enabled", int'(tx_rdy), 1);
        cyc(5);
        put(8'hA5);
        chk("R2", "tx_emt after write", int'(tx_emt), 0);
        rx_frame("R1", 8, 1'b0, 1, d, p, w);
        chk("R1", "data 8 bits", d, 'hA5);
        chk("R3", "start delay within 2", int'(w <= 2), 1);
        cyc(40);
        chk("R2", "txd idle", int'(txd), 1);
        chk("R2", "tx_emt idle", int'(tx_emt), 1);
    endtask

    task automatic t_parity();
        int d, p, w;
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        put(8'hF3);
        rx_frame("R1", 5, 1'b1, 1, d, p, w);
        chk("R1", "5-bit data", d, 'h13);
        chk("R4", "even parity", p, 1);
        cyc(40);
        cfg_len = 2'd2; cfg_par_odd = 1'b1;
        put(8'h55);
        rx_frame("R1", 7, 1'b1, 1, d, p, w);
        chk("R1", "7-bit data", d, 'h55);
        chk("R4", "odd parity", p, 1);
        cyc(40);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_len = 2'd3;
    endtask

    task automatic t_multidrop();
        int d, p, w;
        cfg_multidrop = 1'b1; cfg_addr_flag = 1'b1;
        put(8'h00);
        rx_frame("R5", 8, 1'b1, 1, d, p, w);
        chk("R5", "address data", d, 'h00);
        chk("R5", "address marker", p, 1);
        cyc(40);
        cfg_addr_flag = 1'b0; cfg_par_en = 1'b1;
        put(8'h01);
        rx_frame("R5", 8, 1'b1, 1, d, p, w);
        chk("R5", "data marker", p, 0);
        cyc(40);
        cfg_multidrop = 1'b0; cfg_par_en = 1'b0;
    endtask

    task automatic t_two_stop();
        int d, p, w;
        cfg_two_stop = 1'b1;
        put(8'h3C);
        cyc(4);
        put(8'hC3);
        rx_frame("R6", 8, 1'b0, 2, d, p, w);
        chk("R6", "first byte", d, 'h3C);
        rx_frame("R6", 8, 1'b0, 2, d, p, w);
        chk("R6", "second byte", d, 'hC3);
        cyc(40);
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_break();
        int d, p, w, highs;
        put(8'hFF);
        cyc(60);
        cmd(2);
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            if (txd) highs++;
            cyc(1);
        end
        chk("R7", "high samples during break", highs, 0);
        chk("R7", "tx_emt during break", int'(tx_emt), 0);
        cmd(3);
        cyc(3);
        chk("R7", "line after break", int'(txd), 1);
        chk("R7", "abandoned, empty", int'(tx_emt), 1);
        put(8'h81);
        rx_frame("R7", 8, 1'b0, 1, d, p, w);
        chk("R7", "frame after break", d, 'h81);
        cyc(40);
    endtask

    task automatic t_drain();
        int d, p, w, lows;
        put(8'h11);
        cyc(4);
        put(8'h22);
        cmd(1);
        chk("R8", "tx_rdy after off", int'(tx_rdy), 0);
        rx_frame("R9", 8, 1'b0, 1, d, p, w);
        chk("R9", "drained shifter byte", d, 'h11);
        rx_frame("R9", 8, 1'b0, 1, d, p, w);
        chk("R9", "drained held byte", d, 'h22);
        cyc(40);
        put(8'h33);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            if (!txd) lows++;
            cyc(1);
        end
        chk("R8", "low samples after ignored write", lows, 0);
        chk("R8", "tx_emt after ignored write", int'(tx_emt), 1);
        cmd(0);
    endtask

    task automatic t_cts();
        int d, p, w, lows;
        cfg_cts_en = 1'b1; cts_n = 1'b1;
        put(8'h5A);
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            if (!txd) lows++;
            cyc(1);
        end
        chk("R10", "low samples while blocked", lows, 0);
        chk("R10", "tx_emt while blocked", int'(tx_emt), 0);
        cts_n = 1'b0;
        rx_frame("R10", 8, 1'b0, 1, d, p, w);
        chk("R10", "byte after clear", d, 'h5A);
        cyc(40);
        cfg_cts_en = 1'b0; cts_n = 1'b1;
    endtask

    task automatic t_rts();
        int d, p, w;
        cmd(4);
        chk("R11", "rts_n after on", int'(rts_n), 0);
        cmd(5);
        chk("R11", "rts_n after off", int'(rts_n), 1);
        cmd(4);
        cfg_auto_rts = 1'b1;
        put(8'h0F);
        chk("R12", "rts_n while sending", int'(rts_n), 0);
        rx_frame("R12", 8, 1'b0, 1, d, p, w);
        chk("R12", "byte", d, 'h0F);
        cyc(40);
        chk("R12", "rts_n after empty", int'(rts_n), 1);
        cfg_auto_rts = 1'b0;
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_basic();
        t_parity();
        t_multidrop();
        t_two_stop();
        t_break();
        t_drain();
        t_cts();
        t_rts();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule